// File: doc/BRIEF.md
# Cursor Controller Indirect Register Port

This unit sits between a host bus and the control state of a display cursor controller. The host sees four 16-bit ports, chosen by a 2-bit port select. Two of them load a 16-bit address pointer one byte at a time. The other two are data windows. One carries 8-bit control registers: the command byte, the cursor position and the crosshair window. The other carries 16-bit words of a 512-entry cursor map RAM. Both data windows use the same pointer, and every data access moves the pointer on by one, so the host can stream a block of registers or a whole cursor image after loading a single start address.

Writes take effect at the clock edge where the strobe is sampled. A read strobe returns its data one cycle later, marked by a valid flag. The decoded command byte and the six 12-bit coordinates are presented continuously to the pixel engine. The cursor map RAM has no reset; everything else clears to zero.

Top module: `cursor_regport`

## Requirements
- R1: After reset the pointer, all control registers, the coordinate and command outputs, the read data and the read valid flag are zero.
- R2: Port select 0 writes pointer bits 7:0 and leaves bits 15:8 alone. Port select 1 writes bits 15:8 and leaves bits 7:0 alone. A read on port 0 or port 1 returns the matching pointer byte in bits 7:0, with bits 15:8 zero.
- R3: Each read or write on port 2 or port 3 advances the pointer by one after the access, and 0xFFFF wraps to 0x0000. Accesses on ports 0 and 1 never advance it.
- R4: A write on port 2 stores only bits 7:0 of the data word, and bits 15:8 are ignored.
- R5: A read strobe on any port gives the valid flag and the data exactly one cycle later. A port 2 read returns the register byte in bits 7:0, with bits 15:8 zero.
- R6: The register indices are: 0 command, 1/2 cursor X low/high, 3/4 cursor Y low/high, 5/6 window X, 7/8 window Y, 9/10 window width, 11/12 window height. Each coordinate output is {high[3:0], low[7:0]}.
- R7: A coordinate high register keeps only bits 3:0 of a write and reads bits 7:4 as zero.
- R8: A port 2 access at any pointer value of 13 or above reads zero, and its write changes no register.
- R9: At pointer values 0x000 to 0x1FF, port 3 writes and reads full 16-bit cursor map words.
- R10: At pointer values of 0x200 or above, a port 3 write is ignored and does not alias onto a lower word, and a port 3 read returns zero.
- R11: When read and write strobes are asserted together, the access is a write only: no read data is returned, and the pointer advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Port select: 0 pointer low, 1 pointer high, 2 register data, 3 cursor map data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| cmd_byte | output | 8 | Command register |
| cur_x | output | 12 | Cursor X coordinate |
| cur_y | output | 12 | Cursor Y coordinate |
| win_x | output | 12 | Crosshair window X |
| win_y | output | 12 | Crosshair window Y |
| win_w | output | 12 | Crosshair window width |
| win_h | output | 12 | Crosshair window height |

## Verification
The register file is loaded by one autoincrementing stream of thirteen writes and read back by a second stream. Distinct bytes, differing upper halves and set high nibbles in that data separate a wrong index decode, an upper-byte leak and a missing nibble mask. Streams of cursor map words around the 0x1FF/0x200 edge, followed by a reread of word 0, tell a correct range check apart from an address that aliases. Pointer reads taken after streams, after a 0xFFFF wrap and after a combined read and write strobe show whether the pointer stepped exactly once per data access and never on an address port.

// File: rtl/cregp_pkg.sv
package cregp_pkg;
   typedef enum logic [1:0] {
      PORT_PTR_LO = 2'd0,
      PORT_PTR_HI = 2'd1,
      PORT_REG    = 2'd2,
      PORT_MAP    = 2'd3
   } cregp_port_e;

   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_PTR  = 2'd1,
      RD_REG  = 2'd2,
      RD_MAP  = 2'd3
   } cregp_src_e;

   // register layout: index 0 command, then six low/high coordinate pairs
   localparam int unsigned NUM_REGS  = 13;
   localparam int unsigned NUM_COORD = 6;
   localparam int unsigned IDX_W     = $clog2(NUM_REGS);
endpackage

// File: rtl/cregp_pointer.sv
module cregp_pointer #(
   parameter int unsigned PTR_W  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              step,
   output logic [PTR_W-1:0]  ptr
);
   localparam int unsigned HI_W = PTR_W - BYTE_W;

   generate
      if (HI_W < 1 || HI_W > BYTE_W) begin : g_bad_width
         $error("cregp_pointer: PTR_W must lie between BYTE_W+1 and 2*BYTE_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (ld_lo) begin
         ptr[BYTE_W-1:0] <= byte_in;
      end else if (ld_hi) begin
         ptr[PTR_W-1:BYTE_W] <= byte_in[HI_W-1:0];
      end else if (step) begin
         ptr <= ptr + 1'b1;
      end
   end

   // R3: a data access moves the pointer by exactly one, modulo 2**PTR_W
   a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld_lo && !ld_hi) |=> ptr == PTR_W'($past(ptr) + 1'b1));

   // R2: loading the low byte leaves the high byte untouched
   a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo |=> $stable(ptr[PTR_W-1:BYTE_W]));

   // R2: loading the high byte leaves the low byte untouched
   a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_hi && !ld_lo) |=> $stable(ptr[BYTE_W-1:0]));
endmodule

// File: rtl/cregp_regfile.sv
module cregp_regfile
   import cregp_pkg::*;
#(
   parameter int unsigned PTR_W   = 16,
   parameter int unsigned REG_W   = 8,
   parameter int unsigned COORD_W = 12
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [PTR_W-1:0]                     idx,
   input  logic                                 wr_en,
   input  logic                                 rd_en,
   input  logic [REG_W-1:0]                     wdata,
   output logic [REG_W-1:0]                     rd_q,
   output logic [REG_W-1:0]                     cmd_o,
   output logic [NUM_COORD-1:0][COORD_W-1:0]    coord_o
);
   localparam int unsigned HI_BITS = COORD_W - REG_W;
   localparam int unsigned SLOTS   = 1 << IDX_W;

   generate
      if (HI_BITS < 1 || HI_BITS > REG_W) begin : g_bad_coord
         $error("cregp_regfile: COORD_W must lie between REG_W+1 and 2*REG_W");
      end
   endgenerate

   logic             hit;
   logic [IDX_W-1:0] slot;
   logic [REG_W-1:0] bank [SLOTS];

   assign hit  = (idx < PTR_W'(NUM_REGS));
   assign slot = idx[IDX_W-1:0];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g >= NUM_REGS) begin : g_empty
         assign bank[g] = '0;
      end else if (g == 0 || (g % 2) == 1) begin : g_full
         logic [REG_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    q <= '0;
            else if (wr_en && hit && slot == IDX_W'(g))    q <= wdata;
         end
         assign bank[g] = q;
      end else begin : g_short
         logic [HI_BITS-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    q <= '0;
            else if (wr_en && hit && slot == IDX_W'(g))    q <= wdata[HI_BITS-1:0];
         end
         assign bank[g] = REG_W'(q);
      end
   end

   for (genvar c = 0; c < NUM_COORD; c++) begin : g_coord
      assign coord_o[c] = {bank[2*c+2][HI_BITS-1:0], bank[2*c+1]};
   end

   assign cmd_o = bank[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= hit ? bank[slot] : '0;
   end

   // R7: a coordinate high register never reads back bits above its nibble
   a_r7_high_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && hit && idx != '0 && !idx[0]) |=> (rd_q >> HI_BITS) == '0);

   // R8: a write beyond the last index leaves every register as it was
   a_r8_miss_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit) |=> ($stable(cmd_o) && $stable(coord_o)));
endmodule

// File: rtl/cregp_map.sv
module cregp_map #(
   parameter int unsigned PTR_W = 16,
   parameter int unsigned MAP_W = 16,
   parameter int unsigned DEPTH = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PTR_W-1:0] addr,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [MAP_W-1:0] wdata,
   output logic [MAP_W-1:0] rd_q
);
   localparam int unsigned AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || AW > PTR_W) begin : g_bad_depth
         $error("cregp_map: DEPTH must be at least 2 and reachable by the pointer");
      end
   endgenerate

   logic             in_range;
   logic [AW-1:0]    waddr;
   logic [MAP_W-1:0] mem [DEPTH];

   assign in_range = ({1'b0, addr} < (PTR_W+1)'(DEPTH));
   assign waddr    = addr[AW-1:0];

   // storage carries no reset: the host loads the whole image before use
   always_ff @(posedge clk) begin
      if (wr_en && in_range) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= in_range ? mem[waddr] : '0;
   end
endmodule

// File: rtl/cursor_regport.sv
module cursor_regport
   import cregp_pkg::*;
#(
   parameter int unsigned PTR_W     = 16,
   parameter int unsigned REG_W     = 8,
   parameter int unsigned MAP_W     = 16,
   parameter int unsigned MAP_DEPTH = 512,
   parameter int unsigned COORD_W   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         host_sel,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [MAP_W-1:0]   host_wdata,
   output logic [MAP_W-1:0]   host_rdata,
   output logic               host_rvalid,
   output logic [REG_W-1:0]   cmd_byte,
   output logic [COORD_W-1:0] cur_x,
   output logic [COORD_W-1:0] cur_y,
   output logic [COORD_W-1:0] win_x,
   output logic [COORD_W-1:0] win_y,
   output logic [COORD_W-1:0] win_w,
   output logic [COORD_W-1:0] win_h
);
   generate
      if (MAP_W < REG_W) begin : g_bad_bus
         $error("cursor_regport: MAP_W must be at least REG_W");
      end
   endgenerate

   cregp_port_e sel;
   cregp_src_e  src, src_q;
   logic        rd, wr, data_acc;
   logic [PTR_W-1:0] ptr;
   logic [REG_W-1:0] ptr_byte_q, reg_q;
   logic [MAP_W-1:0] map_q;
   logic [NUM_COORD-1:0][COORD_W-1:0] coord;

   assign sel      = cregp_port_e'(host_sel);
   assign wr       = host_wr;
   assign rd       = host_rd && !host_wr;
   assign data_acc = (wr || rd) && (sel == PORT_REG || sel == PORT_MAP);

   always_comb begin
      unique case (sel)
         PORT_REG: src = RD_REG;
         PORT_MAP: src = RD_MAP;
         default:  src = RD_PTR;
      endcase
   end

   cregp_pointer #(.PTR_W(PTR_W), .BYTE_W(REG_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lo   (wr && sel == PORT_PTR_LO),
      .ld_hi   (wr && sel == PORT_PTR_HI),
      .byte_in (host_wdata[REG_W-1:0]),
      .step    (data_acc),
      .ptr     (ptr)
   );

   cregp_regfile #(.PTR_W(PTR_W), .REG_W(REG_W), .COORD_W(COORD_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (ptr),
      .wr_en   (wr && sel == PORT_REG),
      .rd_en   (rd && sel == PORT_REG),
      .wdata   (host_wdata[REG_W-1:0]),
      .rd_q    (reg_q),
      .cmd_o   (cmd_byte),
      .coord_o (coord)
   );

   cregp_map #(.PTR_W(PTR_W), .MAP_W(MAP_W), .DEPTH(MAP_DEPTH)) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (ptr),
      .wr_en (wr && sel == PORT_MAP),
      .rd_en (rd && sel == PORT_MAP),
      .wdata (host_wdata),
      .rd_q  (map_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q      <= RD_NONE;
         ptr_byte_q <= '0;
      end else begin
         src_q <= rd ? src : RD_NONE;
         if (rd && sel == PORT_PTR_LO) ptr_byte_q <= ptr[REG_W-1:0];
         if (rd && sel == PORT_PTR_HI) ptr_byte_q <= REG_W'(ptr[PTR_W-1:REG_W]);
      end
   end

   always_comb begin
      unique case (src_q)
         RD_PTR:  host_rdata = MAP_W'(ptr_byte_q);
         RD_REG:  host_rdata = MAP_W'(reg_q);
         RD_MAP:  host_rdata = map_q;
         default: host_rdata = '0;
      endcase
   end

   assign host_rvalid = (src_q != RD_NONE);

   assign cur_x = coord[0];
   assign cur_y = coord[1];
   assign win_x = coord[2];
   assign win_y = coord[3];
   assign win_w = coord[4];
   assign win_h = coord[5];

   // R5: a lone read strobe is answered on the following cycle
   a_r5_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr) |=> host_rvalid);

   // R11: a write strobe never produces read data
   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> !host_rvalid);

   // R3: address-port reads leave the pointer where it was
   a_r3_addr_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (sel == PORT_PTR_LO || sel == PORT_PTR_HI)) |=> $stable(ptr));

   // R10: a cursor map read past the RAM returns zero
   a_r10_map_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel == PORT_MAP && {1'b0, ptr} >= (PTR_W+1)'(MAP_DEPTH)) |=> host_rdata == '0);
endmodule

// File: tb/test_cursor_regport.sv
module test_cursor_regport;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  host_sel = 2'd0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [15:0] host_wdata = 16'h0;
   logic [15:0] host_rdata;
   logic        host_rvalid;
   logic [7:0]  cmd_byte;
   logic [11:0] cur_x, cur_y, win_x, win_y, win_w, win_h;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [15:0] exp_q [$];
   string       tag_q [$];

   localparam logic [1:0] P_LO = 2'd0, P_HI = 2'd1, P_REG = 2'd2, P_MAP = 2'd3;

   always #10 clk = ~clk;

   cursor_regport i_cursor_regport (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .cmd_byte(cmd_byte), .cur_x(cur_x),
      .cur_y(cur_y), .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus(input logic [1:0] s, input logic w, input logic r, input logic [15:0] d);
      @(negedge clk);
      host_sel = s; host_wr = w; host_rd = r; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
   endtask

   task automatic wr_port(input logic [1:0] s, input logic [15:0] d);
      bus(s, 1'b1, 1'b0, d);
   endtask

   task automatic rd_port(input logic [1:0] s, input logic [15:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus(s, 1'b0, 1'b1, 16'h0);
   endtask

   task automatic set_ptr(input logic [15:0] v);
      wr_port(P_LO, {v[7:0], v[7:0]});
      wr_port(P_HI, {v[15:8], v[15:8]});
   endtask

   function automatic logic [15:0] pat(input int i);
      return 16'hC000 ^ 16'(i * 16'h0123);
   endfunction

   // monitor: pops the scoreboard as read responses appear
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
               total++; bad++;
               $display("FAIL R11 unexpected read data actual=%h expected=none", host_rdata);
            end else begin
               chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rb [13];
      rb = '{8'h42, 8'h78, 8'h03, 8'h11, 8'h02, 8'hA0, 8'h05,
             8'h0B, 8'h01, 8'hFF, 8'h0F, 8'h33, 8'h0E};
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rvalid", 16'(host_rvalid), 16'h0);
      chk("R1 rdata", host_rdata, 16'h0);
      chk("R1 cmd", 16'(cmd_byte), 16'h0);
      chk("R1 cur_x", 16'(cur_x), 16'h0);
      chk("R1 win_h", 16'(win_h), 16'h0);
      rst_n = 1'b1;
      rd_port(P_LO, 16'h0000, "R1 pointer low after reset");
      rd_port(P_HI, 16'h0000, "R1 pointer high after reset");

      // R2 byte loads, R3 address reads do not step
      wr_port(P_LO, 16'hAA34);
      wr_port(P_HI, 16'h1212);
      rd_port(P_LO, 16'h0034, "R2 pointer low");
      rd_port(P_HI, 16'h0012, "R2 pointer high");
      rd_port(P_LO, 16'h0034, "R3 address read holds pointer");
      wr_port(P_LO, 16'h5656);
      rd_port(P_HI, 16'h0012, "R2 low load keeps high");
      rd_port(P_LO, 16'h0056, "R2 low load value");

      // R4 R6 R7 streamed register writes from index 0
      set_ptr(16'h0000);
      wr_port(P_REG, 16'h1B42);
      wr_port(P_REG, 16'h7878);
      wr_port(P_REG, 16'hC3C3);
      wr_port(P_REG, 16'h1111);
      wr_port(P_REG, 16'h0202);
      wr_port(P_REG, 16'hA0A0);
      wr_port(P_REG, 16'hF5F5);
      wr_port(P_REG, 16'h0B0B);
      wr_port(P_REG, 16'h0101);
      wr_port(P_REG, 16'hFFFF);
      wr_port(P_REG, 16'hFFFF);
      wr_port(P_REG, 16'h3333);
      wr_port(P_REG, 16'h9E9E);
      chk("R4 cmd low byte only", 16'(cmd_byte), 16'h0042);
      chk("R6 R7 cur_x", 16'(cur_x), 16'h0378);
      chk("R6 cur_y", 16'(cur_y), 16'h0211);
      chk("R6 win_x", 16'(win_x), 16'h05A0);
      chk("R6 win_y", 16'(win_y), 16'h010B);
      chk("R6 win_w", 16'(win_w), 16'h0FFF);
      chk("R6 win_h", 16'(win_h), 16'h0E33);
      rd_port(P_LO, 16'h000D, "R3 pointer after 13 writes");

      // R5 R7 streamed read-back
      set_ptr(16'h0000);
      for (int i = 0; i < 13; i++) rd_port(P_REG, 16'(rb[i]), "R5 R7 register read-back");
      rd_port(P_LO, 16'h000D, "R3 pointer after 13 reads");

      // R8 unimplemented indices
      wr_port(P_REG, 16'h5555);
      set_ptr(16'h00FF);
      wr_port(P_REG, 16'h6666);
      set_ptr(16'h000D);
      rd_port(P_REG, 16'h0000, "R8 index 13 reads zero");
      chk("R8 cmd unchanged", 16'(cmd_byte), 16'h0042);
      chk("R8 cur_x unchanged", 16'(cur_x), 16'h0378);
      chk("R8 win_h unchanged", 16'(win_h), 16'h0E33);

      // R9 R10 cursor map
      set_ptr(16'h0000);
      for (int i = 0; i < 8; i++) wr_port(P_MAP, pat(i));
      set_ptr(16'h01FE);
      wr_port(P_MAP, 16'hABCD);
      wr_port(P_MAP, 16'h1234);
      wr_port(P_MAP, 16'hDEAD);
      set_ptr(16'h01FE);
      rd_port(P_MAP, 16'hABCD, "R9 map word 0x1FE");
      rd_port(P_MAP, 16'h1234, "R9 map word 0x1FF");
      rd_port(P_MAP, 16'h0000, "R10 map read past end");
      set_ptr(16'h0000);
      for (int i = 0; i < 8; i++) rd_port(P_MAP, pat(i), "R9 R10 map stream, no alias");

      // R3 wrap
      set_ptr(16'hFFFF);
      rd_port(P_REG, 16'h0000, "R8 index 0xFFFF reads zero");
      rd_port(P_LO, 16'h0000, "R3 wrap low");
      rd_port(P_HI, 16'h0000, "R3 wrap high");

      // R11 simultaneous strobes
      set_ptr(16'h0005);
      bus(P_MAP, 1'b1, 1'b1, 16'hBEEF);
      rd_port(P_LO, 16'h0006, "R11 single step");
      set_ptr(16'h0005);
      rd_port(P_MAP, 16'hBEEF, "R11 write taken");

      repeat (4) @(negedge clk);
      chk("R5 all reads answered", 16'(exp_q.size()), 16'h0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule